// File: doc/BRIEF.md
# Indexed Register Window with Reference-Clock Down-Counter

This block is a controller-side register file that a host reaches only indirectly. Each of two channel windows, primary and secondary, has an index port and a data port. A write to the index port picks a register, and later reads or writes on the data port move that register's contents. The windows sit side by side in one 16-byte address region, selected by address bit 3. The secondary window's ports are therefore 0x08 above the primary's, and each window keeps its own index.

The registers hold clock-synthesiser control bytes, per-drive timing bytes for two drives in each channel, and a cable-type status bit for each channel. They also expose a 30-bit free-running down-counter. The counter runs on a separate reference clock, nominally half the bus clock, and only while a test-mode enable bit is set. Firmware samples the counter, lets it run for a known time, samples it again and derives the reference frequency from the difference.

The counter's 30 bits are split into four byte-wide fields, two in each window. Each field crosses into the bus clock through its own gray-coded synchroniser. There is no snapshot across fields, so software re-reads until two passes agree.

Top module: `idx_regwin`

## Requirements
- R1: A bus write to offset 1 of a window loads that window's 8-bit index. A read at offset 1 returns the index. A read or write at offset 3 transfers the register the index selects. Reads at any other offset, and all reads with `bus_rd` low, return 0x00. The window is chosen by `bus_addr[3]` (0 = primary, 1 = secondary), and the offset is `bus_addr[2:0]`.
- R2: The two windows keep independent indices and independent timing bytes. A write through one window never changes a value read through the other.
- R3: The counter resets to all ones. In the primary window, index 0x20 returns bits [7:0] and index 0x21 returns {0, bits [14:8]}. In the secondary window, index 0x20 returns bits [22:15] and index 0x21 returns {0, bits [29:23]}. The assembled value is `b0 | b1<<8 | b2<<15 | b3<<23`.
- R4: The counter decrements by one on each reference-clock edge while bit 6 of primary index 0x01 is set. It holds its value while that bit is clear. Writes to counter indices, and writes to index 0x01 in the secondary window, have no effect on the counter.
- R5: Each counter field reaches the bus side through a gray-coded synchroniser. A field changes by at most one gray bit per reference clock. Once counting stops, repeated reads return the same value, and while counting, successive consistent reads decrease.
- R6: Index 0x0B in each window returns that channel's `cable_40w` input in bit 2, with all other bits 0. Writes to it are ignored.
- R7: Secondary indices 0x02 and 0x03 are read/write bytes that drive `pll_f` and `pll_r`. Both reset to 0x00.
- R8: Indices 0x0C to 0x1B in each window are read/write timing bytes, reset to 0x00. The byte at index 0x0C+k of window w drives `timing_o[(w*16+k)*8 +: 8]`.
- R9: Primary index 0x01 is a full read/write byte. Every index not named above, including 0x01, 0x02 and 0x03 in the windows where they are not defined, reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| ref_clk | input | 1 | Reference clock that drives the counter |
| ref_rst_n | input | 1 | Reference-domain asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of `clk` |
| bus_rd | input | 1 | Read enable for `bus_rdata` |
| bus_addr | input | 4 | Bit 3 selects the window; bits 2:0 give the port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| cable_40w | input | 2 | Per-channel cable status, bit 0 primary, bit 1 secondary |
| pll_f | output | 8 | Synthesiser feedback value |
| pll_r | output | 8 | Synthesiser reference divider value |
| timing_o | output | 256 | Timing bytes of both windows, packed as in R8 |

## Verification
Register writes take effect at the rising edge that samples the data-port write. Read data is combinational, so the bench samples it one time unit after the falling edge on which it raises `bus_rd`. The cable bit passes through two bus flops, and the bench waits several bus cycles after changing it.

A change of the enable bit reaches the counter after two reference edges. A counter change then needs one reference edge for the gray register and two bus edges for the synchroniser before it shows at the data port. For that reason the bench stops the counter and waits well beyond that path before it compares values. It checks the number of decrements against a tolerance band sized to these edges rather than against an exact count.

// File: rtl/idx_regwin.sv
module idx_regwin #(
  parameter int SYNC_STAGES = 2,
  parameter int TIM_BYTES = 16,
  parameter logic [7:0] TIM_BASE = 8'h0C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ref_clk,
  input  logic                      ref_rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [3:0]                bus_addr,
  input  logic [7:0]                bus_wdata,
  output logic [7:0]                bus_rdata,
  input  logic [1:0]                cable_40w,
  output logic [7:0]                pll_f,
  output logic [7:0]                pll_r,
  output logic [2*TIM_BYTES*8-1:0]  timing_o
);
  localparam int CW = 30;
  localparam int TW = $clog2(TIM_BYTES);
  localparam int EN_BIT = 6;
  localparam logic [7:0] TIM_END  = TIM_BASE + 8'(TIM_BYTES - 1);
  localparam logic [7:0] IX_CTRL  = 8'h01;
  localparam logic [7:0] IX_PLLF  = 8'h02;
  localparam logic [7:0] IX_PLLR  = 8'h03;
  localparam logic [7:0] IX_CABLE = 8'h0B;
  localparam logic [7:0] IX_CLO   = 8'h20;
  localparam logic [7:0] IX_CHI   = 8'h21;
  localparam logic [CW-1:0] FIELD_TOP = CW'((1 << 29) | (1 << 22) | (1 << 14) | (1 << 7));
  localparam logic [CW-1:0] ONES = '1;
  localparam logic [CW-1:0] GRAY_ONES = ONES ^ ((ONES >> 1) & ~FIELD_TOP);

  function automatic logic [CW-1:0] to_gray(input logic [CW-1:0] b);
    return b ^ ((b >> 1) & ~FIELD_TOP);
  endfunction

  function automatic logic [CW-1:0] to_bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    logic acc;
    acc = 1'b0;
    for (int i = CW - 1; i >= 0; i--) begin
      acc = FIELD_TOP[i] ? g[i] : (acc ^ g[i]);
      b[i] = acc;
    end
    return b;
  endfunction

  logic       win;
  logic [2:0] off;
  logic [7:0] idx [2];
  logic [7:0] sel_idx;
  logic [7:0] ctrl;
  logic [7:0] tim [2][TIM_BYTES];
  logic [1:0] cab_s1, cab_s2;
  logic       in_tim;
  logic [7:0] toff8;
  logic [TW-1:0] toff;
  logic [7:0] reg_q;

  assign win     = bus_addr[3];
  assign off     = bus_addr[2:0];
  assign sel_idx = idx[win];
  assign in_tim  = (sel_idx >= TIM_BASE) && (sel_idx <= TIM_END);
  assign toff8   = sel_idx - TIM_BASE;
  assign toff    = toff8[TW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx[0] <= '0;
      idx[1] <= '0;
      ctrl   <= '0;
      pll_f  <= '0;
      pll_r  <= '0;
      cab_s1 <= '0;
      cab_s2 <= '0;
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < TIM_BYTES; k++)
          tim[w][k] <= '0;
    end else begin
      cab_s1 <= cable_40w;
      cab_s2 <= cab_s1;
      if (bus_wr && off == 3'd1) idx[win] <= bus_wdata;
      if (bus_wr && off == 3'd3) begin
        if (in_tim) tim[win][toff] <= bus_wdata;
        else if (!win && sel_idx == IX_CTRL) ctrl <= bus_wdata;
        else if (win && sel_idx == IX_PLLF) pll_f <= bus_wdata;
        else if (win && sel_idx == IX_PLLR) pll_r <= bus_wdata;
      end
    end
  end

  logic [1:0]    en_sync;
  logic [CW-1:0] cnt;
  logic [CW-1:0] gray_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      en_sync <= '0;
      cnt     <= ONES;
      gray_q  <= GRAY_ONES;
    end else begin
      en_sync <= {en_sync[0], ctrl[EN_BIT]};
      if (en_sync[1]) cnt <= cnt - 1'b1;
      gray_q <= to_gray(cnt);
    end
  end

  logic [CW-1:0] gs [SYNC_STAGES];
  logic [CW-1:0] bus_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) gs[i] <= GRAY_ONES;
    end else begin
      gs[0] <= gray_q;
      for (int i = 1; i < SYNC_STAGES; i++) gs[i] <= gs[i-1];
    end
  end

  assign bus_cnt = to_bin(gs[SYNC_STAGES-1]);

  always_comb begin
    reg_q = 8'h00;
    if (in_tim) reg_q = tim[win][toff];
    else begin
      case (sel_idx)
        IX_CTRL:  if (!win) reg_q = ctrl;
        IX_PLLF:  if (win) reg_q = pll_f;
        IX_PLLR:  if (win) reg_q = pll_r;
        IX_CABLE: reg_q = {5'b0, cab_s2[win], 2'b0};
        IX_CLO:   reg_q = win ? bus_cnt[22:15] : bus_cnt[7:0];
        IX_CHI:   reg_q = win ? {1'b0, bus_cnt[29:23]} : {1'b0, bus_cnt[14:8]};
        default:  reg_q = 8'h00;
      endcase
    end
  end

  assign bus_rdata = !bus_rd       ? 8'h00 :
                     (off == 3'd1) ? sel_idx :
                     (off == 3'd3) ? reg_q : 8'h00;

  for (genvar w = 0; w < 2; w++) begin : g_win
    for (genvar k = 0; k < TIM_BYTES; k++) begin : g_byte
      assign timing_o[(w*TIM_BYTES+k)*8 +: 8] = tim[w][k];
    end
  end
endmodule

module idx_regwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_clk,
  input logic        ref_rst_n,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  pll_f,
  input logic [7:0]  pll_r,
  input logic [7:0]  idx_pri,
  input logic [7:0]  idx_sec,
  input logic [1:0]  en_sync,
  input logic [29:0] cnt,
  input logic [29:0] gray_q
);
  assert_hold_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !en_sync[1] |=> cnt == $past(cnt));

  assert_step_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    en_sync[1] |=> cnt == $past(cnt) - 30'd1);

  assert_gray_step_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ($countones(gray_q[7:0]   ^ $past(gray_q[7:0]))   <= 1) &&
    ($countones(gray_q[14:8]  ^ $past(gray_q[14:8]))  <= 1) &&
    ($countones(gray_q[22:15] ^ $past(gray_q[22:15])) <= 1) &&
    ($countones(gray_q[29:23] ^ $past(gray_q[29:23])) <= 1));

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h1) |=> idx_pri == $past(bus_wdata));

  assert_window_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h9) |=> (idx_sec == $past(bus_wdata)) && (idx_pri == $past(idx_pri)));

  assert_pll_f_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hB && idx_sec == 8'h02) |=> pll_f == $past(bus_wdata));

  assert_pll_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hB && idx_sec == 8'h03) |=> pll_r == $past(bus_wdata));
endmodule

bind idx_regwin idx_regwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pll_f(pll_f), .pll_r(pll_r), .idx_pri(idx[0]), .idx_sec(idx[1]),
  .en_sync(en_sync), .cnt(cnt), .gray_q(gray_q)
);

// File: tb/idx_regwin_tb_top.sv
module idx_regwin_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 2 * CLK_PERIOD;
  localparam logic [29:0] ONES = '1;

  logic clk = 0, ref_clk = 0, rst_n = 0, ref_rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cable_40w = '0;
  logic [7:0] pll_f, pll_r;
  logic [255:0] timing_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  idx_regwin dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cable_40w(cable_40w), .pll_f(pll_f), .pll_r(pll_r),
    .timing_o(timing_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_true(input string req, input bit ok, input logic [31:0] act);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=condition", req, act);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic reg_write(input logic sec, input logic [7:0] ix, input logic [7:0] d);
    bus_write({sec, 3'd1}, ix);
    bus_write({sec, 3'd3}, d);
  endtask

  task automatic reg_read(input logic sec, input logic [7:0] ix, output logic [7:0] d);
    bus_write({sec, 3'd1}, ix);
    bus_read({sec, 3'd3}, d);
  endtask

  task automatic read_count(output logic [29:0] c);
    logic [7:0] b0, b1, b2, b3;
    logic [29:0] prev;
    prev = '0;
    c = '0;
    for (int t = 0; t < 4; t++) begin
      prev = c;
      reg_read(0, 8'h20, b0);
      reg_read(0, 8'h21, b1);
      reg_read(1, 8'h20, b2);
      reg_read(1, 8'h21, b3);
      c = {b3[6:0], 23'b0} | {7'b0, b2, 15'b0} | {15'b0, b1[6:0], 8'b0} | {22'b0, b0};
      if (t > 0 && c == prev) break;
    end
  endtask

  // {secondary, index, write data, expected read-back}
  localparam logic [24:0] VEC [11] = '{
    {1'b0, 8'h0C, 8'hA5, 8'hA5},  // R8
    {1'b1, 8'h1B, 8'h3C, 8'h3C},  // R8
    {1'b0, 8'h02, 8'h55, 8'h00},  // R9
    {1'b1, 8'h02, 8'h44, 8'h44},  // R7
    {1'b1, 8'h03, 8'h0D, 8'h0D},  // R7
    {1'b0, 8'h20, 8'h12, 8'hFF},  // R4
    {1'b1, 8'h01, 8'h40, 8'h00},  // R9
    {1'b0, 8'h13, 8'h03, 8'h03},  // R8
    {1'b0, 8'h7F, 8'hEE, 8'h00},  // R9
    {1'b1, 8'h0C, 8'h99, 8'h99},  // R8
    {1'b1, 8'h21, 8'h00, 8'h7F}   // R3
  };
  localparam string VTAG [11] = '{"R8", "R8", "R9", "R7", "R7", "R4", "R9", "R8", "R9", "R8", "R3"};

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [29:0] c1, c2, ca, cb;
    repeat (4) @(negedge clk);
    rst_n = 1; ref_rst_n = 1;
    repeat (4) @(negedge clk);

    check("R7 reset pll_f", pll_f, 0);
    check("R7 reset pll_r", pll_r, 0);
    check_true("R8 reset timing", timing_o == '0, 0);
    bus_read(4'h1, d);
    check("R1 reset index", d, 0);
    read_count(c1);
    check("R3 reset count", c1, ONES);

    foreach (VEC[i]) begin
      reg_write(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      reg_read(VEC[i][24], VEC[i][23:16], d);
      check(VTAG[i], d, VEC[i][7:0]);
    end

    reg_read(0, 8'h0C, d);
    check("R2 primary timing kept", d, 8'hA5);
    check("R8 timing_o pri 0x0C", timing_o[7:0], 8'hA5);
    check("R8 timing_o sec 0x1B", timing_o[31*8 +: 8], 8'h3C);
    check("R8 timing_o sec 0x0C", timing_o[16*8 +: 8], 8'h99);
    check("R7 pll_f port", pll_f, 8'h44);
    check("R7 pll_r port", pll_r, 8'h0D);

    bus_write(4'h1, 8'h5A);
    bus_write(4'h9, 8'hC3);
    bus_read(4'h1, d);
    check("R2 primary index kept", d, 8'h5A);
    bus_read(4'h9, d);
    check("R1 secondary index read", d, 8'hC3);
    bus_read(4'h0, d);
    check("R1 offset 0 reads zero", d, 0);
    bus_read(4'hF, d);
    check("R1 offset 7 reads zero", d, 0);

    cable_40w = 2'b10;
    repeat (5) @(negedge clk);
    reg_read(0, 8'h0B, d);
    check("R6 primary cable", d, 8'h00);
    reg_read(1, 8'h0B, d);
    check("R6 secondary cable", d, 8'h04);
    reg_write(1, 8'h0B, 8'hFF);
    reg_read(1, 8'h0B, d);
    check("R6 cable write ignored", d, 8'h04);

    repeat (100) @(negedge clk);
    read_count(c1);
    check("R4 counter idle after secondary write", c1, ONES);

    reg_write(0, 8'h01, 8'h40);
    repeat (700) @(negedge clk);
    reg_write(0, 8'h01, 8'h00);
    repeat (30) @(negedge clk);
    read_count(c1);
    check_true("R4 decrement count in band", (ONES - c1) >= 30'd345 && (ONES - c1) <= 30'd358, ONES - c1);
    check_true("R3 low field borrowed", c1[14:8] != 7'h7F, c1);
    repeat (50) @(negedge clk);
    read_count(c2);
    check("R5 frozen value stable", c2, c1);

    reg_write(0, 8'h01, 8'hBF);
    reg_read(0, 8'h01, d);
    check("R9 control byte readback", d, 8'hBF);
    repeat (50) @(negedge clk);
    read_count(c2);
    check("R4 frozen without bit 6", c2, c1);

    reg_write(0, 8'h01, 8'h40);
    repeat (20) @(negedge clk);
    read_count(ca);
    repeat (100) @(negedge clk);
    read_count(cb);
    check_true("R5 running reads decrease", cb < ca, cb);
    reg_write(0, 8'h20, 8'h00);
    reg_write(0, 8'h01, 8'h00);
    repeat (30) @(negedge clk);
    read_count(c2);
    check_true("R4 counter write ignored", c2 < cb && c2 != 30'd0, c2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule